// File: doc/BRIEF.md
# Atomic Load-and-Operate Memory Unit

This block executes a small family of atomic read-modify-write instructions against a simple synchronous memory port. It decodes a 32-bit instruction word and takes the base and addend register values from the pipeline. The memory location addressed by the base register is then read and rewritten in one indivisible locked pair of accesses. The block hands back the previous memory contents, together with the destination register number, for write-back.

Six operations exist, each in a 32-bit word form and a 64-bit doubleword form. Three of them add a value to memory: a constant +1 (increment), a constant -1 (decrement), or the addend register (add). The other three exchange memory with a value: all ones (set), zero (clear), or the addend register (swap). A mode input allows or blocks the doubleword forms. An endianness input selects the byte order in memory. Malformed encodings, disallowed doubleword forms and misaligned addresses end in a fault with no memory traffic.

Top module: `amo_unit`

## Requirements
- R1: An instruction is recognised only when bits [31:26] are 011100 and bits [5:0] are 011111. Any other accepted word, or an unused code in bits [10:6], raises `fault_ri` in the done cycle and causes no memory access.
- R2: Bits [10:6] select the operation and bit 6 selects doubleword (1) or word (0). The codes are 0001x increment, 0011x decrement, 1001x add register, 0101x set, 0111x clear and 1011x swap. Bits [15:11] name the destination, and the address is the base value with no offset.
- R3: Increment, decrement and add write old+operand to memory, using +1, -1 or the addend register. The old value is returned.
- R4: Set writes all ones, clear writes zero and swap writes the addend register. Each returns the previous memory contents.
- R5: Word forms use only the low 32 bits of the addend and drive zero on `mem_wdata[63:32]`. They return the 32-bit old value sign-extended to 64 bits.
- R6: For increment, decrement, set and clear, bits [20:16] must be zero. Any other value there raises `fault_ri` with no memory access.
- R7: A doubleword form with `mode64` low raises `fault_ri` and causes no memory access.
- R8: A word address not 4-byte aligned, or a doubleword address not 8-byte aligned, raises `fault_ae` with no memory access.
- R9: On the data port, byte k of `mem_rdata`/`mem_wdata` (bits [8k+7:8k]) belongs to address `mem_addr`+k. With `big_endian` low the lowest address holds the least significant byte. With it high the lowest address holds the most significant byte of the access.
- R10: After acceptance the unit issues one read cycle and then one write cycle to the same address, with `mem_lock` high in both. The done pulse comes 3 cycles after the accepting edge. A faulted instruction gives its done pulse 1 cycle after that edge.
- R11: `in_ready` is high only while idle. `done` is a one-cycle pulse carrying `result` and `rd_idx`. `wb_en` is high with `done` only when no fault is raised, and `result` is zero on a fault.
- R12: After reset the unit is idle: `in_ready`=1, and `mem_req`, `done`, `wb_en` and both faults are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, offer is taken on this edge |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Base register value (address) |
| addend_val | input | 64 | Addend register value |
| mode64 | input | 1 | Doubleword forms allowed |
| big_endian | input | 1 | Memory byte order select |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Memory held for the read/write pair |
| mem_dw | output | 1 | Access is 8 bytes (else 4) |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data, byte k at address+k |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |
| done | output | 1 | Completion pulse |
| result | output | 64 | Old memory value for write-back |
| rd_idx | output | 5 | Destination register number |
| wb_en | output | 1 | Write-back allowed |
| fault_ri | output | 1 | Reserved-instruction fault |
| fault_ae | output | 1 | Address-error fault |

## Verification
Several corner cases get direct attention. A word decrement of zero must store 0xFFFFFFFF with zero upper data bits and return zero; a unit that kept the sum as 64 bits would put ones on the upper data lane. A word old value of 0x80000000 must come back as 0xFFFFFFFF80000000; a unit that extended with zeros would return a positive number. Set and clear must return the previous contents rather than the value written. A word add whose addend carries high bits must ignore those bits. The bench also sends increment with a nonzero addend field, doubleword forms with 64-bit mode off, and misaligned addresses; a lax decoder or alignment check would show memory traffic on these and corrupt the bench memory. Both byte orders are run, so a unit that ignored the endianness select would leave the wrong bytes in memory.

// File: rtl/amo_pkg.sv
package amo_pkg;
    localparam int XLEN   = 64;
    localparam int WLEN   = 32;
    localparam int REGW   = 5;
    localparam int IW     = 32;
    localparam int XBYTES = XLEN / 8;
    localparam int WBYTES = WLEN / 8;

    localparam logic [5:0] MAJOR_OP = 6'b011100;
    localparam logic [5:0] MINOR_OP = 6'b011111;

    typedef enum logic [2:0] {
        OP_NONE, OP_INC, OP_DEC, OP_ADD, OP_SET, OP_CLR, OP_SWP
    } amo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_DONE
    } amo_st_e;

    typedef struct packed {
        logic             legal;
        amo_op_e          op;
        logic             dw;
        logic [REGW-1:0]  rd;
    } amo_dec_t;

    function automatic logic [XLEN-1:0] swap_x(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XBYTES; i++)
            r[8*i +: 8] = v[8*(XBYTES-1-i) +: 8];
        return r;
    endfunction

    function automatic logic [WLEN-1:0] swap_w(input logic [WLEN-1:0] v);
        logic [WLEN-1:0] r;
        for (int i = 0; i < WBYTES; i++)
            r[8*i +: 8] = v[8*(WBYTES-1-i) +: 8];
        return r;
    endfunction

    function automatic logic is_add_class(input amo_op_e op);
        return (op == OP_INC) || (op == OP_DEC) || (op == OP_ADD);
    endfunction
endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [IW-1:0] instr,
    output amo_dec_t      dec
);
    logic [4:0]      func;
    logic [REGW-1:0] rt;
    logic            frame_ok;
    logic            needs_zero_rt;

    always_comb begin
        func          = instr[10:6];
        rt            = instr[20:16];
        frame_ok      = (instr[31:26] == MAJOR_OP) && (instr[5:0] == MINOR_OP);
        dec.dw        = func[0];
        dec.rd        = instr[15:11];
        needs_zero_rt = 1'b1;
        case (func[4:1])
            4'b0001: dec.op = OP_INC;
            4'b0011: dec.op = OP_DEC;
            4'b1001: begin dec.op = OP_ADD; needs_zero_rt = 1'b0; end
            4'b0101: dec.op = OP_SET;
            4'b0111: dec.op = OP_CLR;
            4'b1011: begin dec.op = OP_SWP; needs_zero_rt = 1'b0; end
            default: dec.op = OP_NONE;
        endcase
        dec.legal = frame_ok && (dec.op != OP_NONE)
                    && !(needs_zero_rt && (rt != '0));
    end
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
    import amo_pkg::*;
(
    input  amo_op_e         op,
    input  logic            dw,
    input  logic            be,
    input  logic [XLEN-1:0] addend,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] old_value,
    output logic [XLEN-1:0] wdata
);
    logic [WLEN-1:0] old_w;
    logic [XLEN-1:0] old_x;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] newv;
    logic [WLEN-1:0] new_w;

    always_comb begin
        old_w = be ? swap_w(rdata[WLEN-1:0]) : rdata[WLEN-1:0];
        old_x = be ? swap_x(rdata) : rdata;
        old_value = dw ? old_x : {{(XLEN-WLEN){old_w[WLEN-1]}}, old_w};

        case (op)
            OP_INC:  operand = XLEN'(1);
            OP_DEC:  operand = '1;
            OP_SET:  operand = '1;
            OP_ADD,
            OP_SWP:  operand = dw ? addend
                                  : {{(XLEN-WLEN){1'b0}}, addend[WLEN-1:0]};
            default: operand = '0;
        endcase

        newv  = is_add_class(op) ? (old_value + operand) : operand;
        new_w = newv[WLEN-1:0];
        wdata = dw ? (be ? swap_x(newv) : newv)
                   : {{(XLEN-WLEN){1'b0}}, (be ? swap_w(new_w) : new_w)};
    end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  amo_dec_t        dec_in,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] addend_val,
    input  logic            mode64,
    input  logic            big_endian,
    input  logic [XLEN-1:0] old_value,
    output logic            in_ready,
    output amo_op_e         cur_op,
    output logic            cur_dw,
    output logic            cur_be,
    output logic [XLEN-1:0] cur_addend,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_lock,
    output logic [XLEN-1:0] mem_addr,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic [REGW-1:0] rd_idx,
    output logic            wb_en,
    output logic            fault_ri,
    output logic            fault_ae
);
    amo_st_e         state;
    logic            accept;
    logic            ri_now;
    logic            ae_now;
    logic [2:0]      align_mask;

    always_comb begin
        accept     = in_valid && (state == ST_IDLE);
        ri_now     = !dec_in.legal || (dec_in.dw && !mode64);
        align_mask = dec_in.dw ? 3'b111 : 3'b011;
        ae_now     = !ri_now && ((base_val[2:0] & align_mask) != 3'b000);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_op     <= OP_NONE;
            cur_dw     <= 1'b0;
            cur_be     <= 1'b0;
            cur_addend <= '0;
            mem_addr   <= '0;
            result     <= '0;
            rd_idx     <= '0;
            fault_ri   <= 1'b0;
            fault_ae   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    cur_op     <= dec_in.op;
                    cur_dw     <= dec_in.dw;
                    cur_be     <= big_endian;
                    cur_addend <= addend_val;
                    mem_addr   <= base_val;
                    rd_idx     <= dec_in.rd;
                    result     <= '0;
                    fault_ri   <= ri_now;
                    fault_ae   <= ae_now;
                    state      <= (ri_now || ae_now) ? ST_DONE : ST_READ;
                end
                ST_READ:  state <= ST_WRITE;
                ST_WRITE: begin
                    result <= old_value;
                    state  <= ST_DONE;
                end
                default: begin
                    fault_ri <= 1'b0;
                    fault_ae <= 1'b0;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        in_ready = (state == ST_IDLE);
        mem_req  = (state == ST_READ) || (state == ST_WRITE);
        mem_we   = (state == ST_WRITE);
        mem_lock = mem_req;
        done     = (state == ST_DONE);
        wb_en    = done && !fault_ri && !fault_ae;
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] addend_val,
    input  logic            mode64,
    input  logic            big_endian,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_lock,
    output logic            mem_dw,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic [REGW-1:0] rd_idx,
    output logic            wb_en,
    output logic            fault_ri,
    output logic            fault_ae
);
    amo_dec_t        dec;
    amo_op_e         cur_op;
    logic            cur_dw;
    logic            cur_be;
    logic [XLEN-1:0] cur_addend;
    logic [XLEN-1:0] old_value;

    amo_decode u_dec (.instr(instr), .dec(dec));

    amo_seq u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dec_in(dec),
        .base_val(base_val), .addend_val(addend_val), .mode64(mode64),
        .big_endian(big_endian), .old_value(old_value), .in_ready(in_ready),
        .cur_op(cur_op), .cur_dw(cur_dw), .cur_be(cur_be),
        .cur_addend(cur_addend), .mem_req(mem_req), .mem_we(mem_we),
        .mem_lock(mem_lock), .mem_addr(mem_addr), .done(done),
        .result(result), .rd_idx(rd_idx), .wb_en(wb_en),
        .fault_ri(fault_ri), .fault_ae(fault_ae)
    );

    amo_datapath u_dp (
        .op(cur_op), .dw(cur_dw), .be(cur_be), .addend(cur_addend),
        .rdata(mem_rdata), .old_value(old_value), .wdata(mem_wdata)
    );

    assign mem_dw = cur_dw;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_lock,
    input logic [63:0] mem_addr,
    input logic        done,
    input logic        fault_ri,
    input logic        fault_ae
);
    a_r10_lock_covers_access: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);

    a_r10_write_after_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we && $stable(mem_addr)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_ready);

    a_r8_fault_no_access: assert property (@(posedge clk) disable iff (rst)
        (fault_ri || fault_ae) |-> (!mem_req && $past(!mem_req)));

    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> (in_ready && !mem_req && !done));
endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .done(done), .fault_ri(fault_ri), .fault_ae(fault_ae)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] instr;
    logic [63:0] base_val, addend_val;
    logic        mode64, big_endian;
    logic        mem_req, mem_we, mem_lock, mem_dw;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata;
    logic        done;
    logic [63:0] result;
    logic [4:0]  rd_idx;
    logic        wb_en, fault_ri, fault_ae;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_unit u0 (.*);

    // behavioural memory: byte k of the data bus maps to address+k
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < (mem_dw ? 8 : 4); k++)
                    mem[(mem_addr[7:0] + k) & 8'hff] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= '0;
                for (int k = 0; k < (mem_dw ? 8 : 4); k++)
                    mem_rdata[8*k +: 8] <= mem[(mem_addr[7:0] + k) & 8'hff];
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [4:0] func, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
        return {6'b011100, rs, rt, rd, func, 6'b011111};
    endfunction

    // reference: read n bytes from the bench memory in chosen order
    function automatic logic [63:0] load_val(input int a, input int n, input bit be);
        logic [63:0] v = '0;
        for (int k = 0; k < n; k++) begin
            if (be) v = (v << 8) | 64'(mem[(a + k) & 255]);
            else    v = v | (64'(mem[(a + k) & 255]) << (8 * k));
        end
        return v;
    endfunction

    // bytes the reference expects on the data bus for a value
    function automatic logic [63:0] bus_of(input logic [63:0] v, input int n, input bit be);
        logic [63:0] r = '0;
        for (int k = 0; k < n; k++) begin
            if (be) r[8*k +: 8] = v[8*(n-1-k) +: 8];
            else    r[8*k +: 8] = v[8*k +: 8];
        end
        return r;
    endfunction

    task automatic put(input int a, input logic [63:0] v, input int n, input bit be);
        logic [63:0] b = bus_of(v, n, be);
        for (int k = 0; k < n; k++) mem[(a + k) & 255] = b[8*k +: 8];
    endtask

    // expect_flt: 0 none, 1 reserved instruction, 2 address error
    task automatic run_op(input string req, input logic [31:0] iw,
                          input logic [63:0] base, input logic [63:0] addv,
                          input bit m64, input bit be, input int expect_flt);
        logic [4:0]  func = iw[10:6];
        bit          dw = iw[6];
        int          n = dw ? 8 : 4;
        int          a = int'(base[7:0]);
        logic [63:0] old, opnd, nv, old_ret, exp_bus;
        logic [7:0]  snap [0:15];
        bit          is_add;

        old = load_val(a, n, be);
        old_ret = dw ? old : {{32{old[31]}}, old[31:0]};
        is_add = (func[4:1] == 4'b0001) || (func[4:1] == 4'b0011) || (func[4:1] == 4'b1001);
        case (func[4:1])
            4'b0001: opnd = 64'd1;
            4'b0011: opnd = '1;
            4'b0101: opnd = '1;
            4'b0111: opnd = '0;
            default: opnd = dw ? addv : {32'h0, addv[31:0]};
        endcase
        nv = is_add ? (old_ret + opnd) : opnd;
        if (!dw) nv = {32'h0, nv[31:0]};
        exp_bus = bus_of(nv, n, be);
        for (int k = 0; k < 16; k++) snap[k] = mem[(a + k) & 255];

        @(negedge clk);
        chk("R11", "ready before issue", 64'(in_ready), 64'd1);
        in_valid = 1'b1; instr = iw; base_val = base; addend_val = addv;
        mode64 = m64; big_endian = be;
        @(negedge clk);
        in_valid = 1'b0; instr = '0; base_val = '0; addend_val = '0;
        if (expect_flt != 0) begin
            chk(req, "fault done", 64'(done), 64'd1);
            chk(req, "fault_ri", 64'(fault_ri), 64'(expect_flt == 1));
            chk(req, "fault_ae", 64'(fault_ae), 64'(expect_flt == 2));
            chk("R11", "wb_en on fault", 64'(wb_en), 64'd0);
            chk("R11", "result on fault", result, 64'd0);
            chk(req, "no mem req", 64'(mem_req), 64'd0);
            for (int k = 0; k < 16; k++)
                chk(req, "memory untouched", 64'(mem[(a + k) & 255]), 64'(snap[k]));
        end else begin
            chk("R10", "read cycle", {61'd0, mem_req, mem_we, mem_lock}, 64'b101);
            chk("R2", "address", mem_addr, base);
            chk("R9", "size", 64'(mem_dw), 64'(dw));
            @(negedge clk);
            chk("R10", "write cycle", {61'd0, mem_req, mem_we, mem_lock}, 64'b111);
            chk(req, "write data", mem_wdata, exp_bus);
            @(negedge clk);
            chk("R10", "done timing", 64'(done), 64'd1);
            chk(req, "result", result, old_ret);
            chk("R2", "rd", 64'(rd_idx), 64'(iw[15:11]));
            chk("R11", "wb_en", 64'(wb_en), 64'd1);
            chk(req, "no fault", {62'd0, fault_ri, fault_ae}, 64'd0);
            chk(req, "memory after", load_val(a, n, be), nv);
        end
        @(negedge clk);
        chk("R11", "done is one pulse", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 3);
        mem_rdata = '0;
        rst = 1'b1; in_valid = 1'b0; instr = '0; base_val = '0; addend_val = '0;
        mode64 = 1'b1; big_endian = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "reset ready", 64'(in_ready), 64'd1);
        chk("R12", "reset outputs", {59'd0, mem_req, done, wb_en, fault_ri, fault_ae}, 64'd0);
        rst = 1'b0;

        // R3 increment, word, little endian
        put(16, 64'h0000_0000_1234_5678, 4, 0);
        run_op("R3", enc(5'b00010, 5'd1, 5'd0, 5'd7), 64'd16, 64'hdead, 1, 0, 0);
        // R3 increment, doubleword
        put(24, 64'h0123_4567_89ab_cdef, 8, 0);
        run_op("R3", enc(5'b00011, 5'd2, 5'd0, 5'd9), 64'd24, 64'd0, 1, 0, 0);
        // R5 decrement of zero wraps in 32 bits
        put(32, 64'd0, 4, 0);
        run_op("R5", enc(5'b00110, 5'd3, 5'd0, 5'd4), 64'd32, 64'd0, 1, 0, 0);
        // R5 word add ignores addend high bits; sign-extended old
        put(36, 64'h0000_0000_8000_0000, 4, 0);
        run_op("R5", enc(5'b10010, 5'd3, 5'd5, 5'd31), 64'd36, 64'hffff_0000_0000_0005, 1, 0, 0);
        // R3 doubleword add with carry across halves
        put(40, 64'h0000_0000_ffff_ffff, 8, 0);
        run_op("R3", enc(5'b10011, 5'd3, 5'd5, 5'd1), 64'd40, 64'd1, 1, 0, 0);
        // R4 set, clear, swap
        put(48, 64'h0000_0000_0bad_f00d, 4, 0);
        run_op("R4", enc(5'b01010, 5'd6, 5'd0, 5'd2), 64'd48, 64'd0, 1, 0, 0);
        run_op("R4", enc(5'b01111, 5'd6, 5'd0, 5'd3), 64'd56, 64'd0, 1, 0, 0);
        run_op("R4", enc(5'b10110, 5'd6, 5'd8, 5'd10), 64'd48, 64'h1111_2222_8765_4321, 1, 0, 0);
        run_op("R4", enc(5'b10111, 5'd6, 5'd8, 5'd11), 64'd64, 64'hfeed_face_cafe_beef, 1, 0, 0);
        // R9 big endian word and doubleword
        put(72, 64'h0000_0000_7fff_ffff, 4, 1);
        run_op("R9", enc(5'b00010, 5'd1, 5'd0, 5'd12), 64'd72, 64'd0, 1, 1, 0);
        put(80, 64'h00ff_0000_0000_0001, 8, 1);
        run_op("R9", enc(5'b10011, 5'd1, 5'd2, 5'd13), 64'd80, 64'h100, 1, 1, 0);
        // R6 reserved nonzero addend field
        run_op("R6", enc(5'b00010, 5'd1, 5'd4, 5'd7), 64'd16, 64'd0, 1, 0, 1);
        run_op("R6", enc(5'b01110, 5'd1, 5'd1, 5'd7), 64'd16, 64'd0, 1, 0, 1);
        // R7 doubleword without 64-bit mode
        run_op("R7", enc(5'b00011, 5'd1, 5'd0, 5'd7), 64'd24, 64'd0, 0, 0, 1);
        // R8 misaligned word and doubleword
        run_op("R8", enc(5'b00010, 5'd1, 5'd0, 5'd7), 64'd18, 64'd0, 1, 0, 2);
        run_op("R8", enc(5'b10111, 5'd1, 5'd2, 5'd7), 64'd28, 64'd5, 1, 0, 2);
        // R1 wrong major/minor codes and unused function code
        run_op("R1", enc(5'b00010, 5'd1, 5'd0, 5'd7) ^ 32'h8000_0000, 64'd16, 64'd0, 1, 0, 1);
        run_op("R1", enc(5'b00010, 5'd1, 5'd0, 5'd7) ^ 32'h0000_0001, 64'd16, 64'd0, 1, 0, 1);
        run_op("R1", enc(5'b00000, 5'd1, 5'd0, 5'd7), 64'd16, 64'd0, 1, 0, 1);
        // word form still legal with 64-bit mode off
        run_op("R7", enc(5'b00010, 5'd1, 5'd0, 5'd7), 64'd16, 64'd0, 0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule